// File: doc/BRIEF.md
# Floppy-to-Host DMA Bus Master

This block lets a floppy disk controller move bytes straight into or out of the memory of an 8-bit host computer, which is too slow to service the controller's data rate by program. When the controller raises its DMA request, the block waits for the start of a host machine cycle (a falling edge of the host's phi2 clock) and then pulls the host's active-low DMA/halt line, which stops the CPU and frees the address, data and R/W lines. While it holds the bus, the block drives a 16-bit memory address, the host R/W level and, when reading from disk, the data byte from the controller. It acknowledges each granted cycle to the controller.

The memory address comes from two parts. The low 11 bits are a counter that steps once per transferred byte on each falling phi2 edge. The upper 5 bits come from a page register that also holds the transfer direction. Software writes this register once before a transfer, through a 16-byte window in the host's I/O space. The controller's end-of-transfer interrupt clears the counter and forces the bus to be released. The interrupt is also passed to the host's open-drain IRQ line, but only while no DMA request is pending.

All logic runs on a fast system clock `clk_i`. phi2 is sampled through a two-stage synchronizer. Tri-state host lines are modelled as a value plus an output enable.

Top module: `retro_dma_engine`

## Requirements
- R1: After reset, `dma_no` is high, `dack_o`, `irq_pull_o`, `addr_oe_o`, `host_rw_oe_o` and `host_data_oe_o` are low, the counter is 0, and the page register is 0.
- R2: The bus is taken (`dma_no` goes low) only on a falling phi2 edge that is seen while `drq_i` is high and `fdc_irq_i` is low. `dma_no` goes low at the second rising `clk_i` edge after `phi2_i` falls. A request that arrives while phi2 is high waits for the next fall.
- R3: While `dma_no` is low, `addr_o` = {page[4:0], counter[10:0]} with `addr_oe_o` high. While `dma_no` is high, `addr_oe_o` is low.
- R4: While the bus is held, each later falling phi2 edge adds 1 to the 11-bit counter, modulo 2048, and leaves the page unchanged. The fall that starts a grab does not count.
- R5: The page register loads `host_data_i[5:0]` on every `clk_i` edge at which `phi2_i` is high, `host_rw_i` is low (write), `host_addr_i` is in 0xDFE0–0xDFEF, and the bus is not held. Bits [4:0] become address bits 15..11 and bit 5 is the direction (1 = disk to host). Writes outside the window, read accesses, and writes while the bus is held are ignored.
- R6: While the bus is held with direction 1, `host_rw_o` is 0 (memory write) and `host_data_o` = `fdc_data_i` with `host_data_oe_o` high. With direction 0, `host_rw_o` is 1 and `host_data_oe_o` is low. `host_rw_oe_o` equals the held state. `fdc_dir_o` shows the direction bit. `fdc_data_o` always equals `host_data_i`.
- R7: While `fdc_irq_i` is high, the counter is cleared and the bus is released (or stays released) at the next `clk_i` edge.
- R8: `irq_pull_o` = `fdc_irq_i` AND NOT `drq_i`, combinationally.
- R9: A falling phi2 edge seen while the bus is held and `drq_i` is low releases the bus. That last cycle's byte still advances the counter.
- R10: `dack_o` is high exactly while `dma_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than phi2 |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phi2_i | input | 1 | Host phase-2 clock (asynchronous) |
| host_addr_i | input | 16 | Host address bus as seen by the block |
| host_data_i | input | 8 | Host data bus as seen by the block |
| host_rw_i | input | 1 | Host R/W (1 read, 0 write) |
| drq_i | input | 1 | Controller DMA request, active high |
| fdc_irq_i | input | 1 | Controller interrupt, active high |
| fdc_data_i | input | 8 | Byte supplied by the controller |
| dma_no | output | 1 | Host DMA/halt line, active low |
| addr_o | output | 16 | Address driven onto the host bus |
| addr_oe_o | output | 1 | Enable for `addr_o` |
| host_rw_o | output | 1 | R/W level driven during DMA |
| host_rw_oe_o | output | 1 | Enable for `host_rw_o` |
| host_data_o | output | 8 | Data driven onto the host bus |
| host_data_oe_o | output | 1 | Enable for `host_data_o` |
| irq_pull_o | output | 1 | Pull-down enable for the open-drain host IRQ |
| dack_o | output | 1 | DMA acknowledge to the controller |
| fdc_dir_o | output | 1 | Direction to the controller (1 disk to host) |
| fdc_data_o | output | 8 | Host data forwarded to the controller |

## Verification
A wrong counter or page value shows on `addr_o` in the cycle the bus is granted, and it stays visible for every byte of the transfer. A synchronizer that fires on the wrong phi2 edge makes `dma_no` fall half a phi2 period early or late, within a few system clocks. A held state that never clears shows as `dma_no` staying low after a request or interrupt ends. The bench keeps a behavioural model running alongside the design and compares every output on every system clock, so each of these faults is caught in the clock where it first appears.

// File: rtl/retro_dma_pkg.sv
package retro_dma_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } grab_state_e;

  function automatic logic in_window(input logic [15:0] a, input logic [15:0] base,
                                     input logic [15:0] mask);
    return (a & mask) == (base & mask);
  endfunction
endpackage

// File: rtl/dma_phi2_edge.sv
module dma_phi2_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_i,
  output logic fall_o
);
  logic [SYNC_N-1:0] sh_q;

  generate
    if (SYNC_N < 2) begin : g_bad
      initial $error("SYNC_N must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-2:0], phi2_i};
  end

  assign fall_o = sh_q[SYNC_N-1] & ~sh_q[SYNC_N-2];

  // a fall needs a high sample one stage earlier
  p_fall_after_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(sh_q[SYNC_N-2]));
endmodule

// File: rtl/dma_grab_ctrl.sv
module dma_grab_ctrl
  import retro_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic drq_i,
  input  logic fdc_irq_i,
  output logic hold_o,
  output logic step_o,
  output logic clr_o
);
  grab_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (fdc_irq_i)   state_d = ST_IDLE;
    else if (fall_i) state_d = drq_i ? ST_HOLD : ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign hold_o = (state_q == ST_HOLD);
  assign step_o = hold_o & fall_i & ~fdc_irq_i;
  assign clr_o  = fdc_irq_i;

  p_grab_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(fall_i && drq_i && !fdc_irq_i));

  p_irq_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdc_irq_i |=> !hold_o);

  p_release_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(fdc_irq_i || (fall_i && !drq_i)));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int CNT_W  = 11,
  parameter int ADDR_W = 16,
  localparam int PAGE_W = ADDR_W - CNT_W,
  localparam int REG_W  = PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_d_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dir_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  // transparent while selected; frozen whenever the bus is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  page_q <= '0;
    else if (reg_we_i && !hold_i) page_q <= reg_d_i;
  end

  assign addr_o = {page_q[PAGE_W-1:0], cnt_q};
  assign dir_o  = page_q[PAGE_W];

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_cnt_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q));

  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  p_page_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(page_q));
endmodule

// File: rtl/retro_dma_engine.sv
module retro_dma_engine
  import retro_dma_pkg::*;
#(
  parameter int          CNT_W    = 11,
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          SYNC_N   = 2,
  parameter logic [15:0] WIN_BASE = 16'hDFE0,
  parameter logic [15:0] WIN_MASK = 16'hFFF0,
  localparam int PAGE_W = ADDR_W - CNT_W,
  localparam int REG_W  = PAGE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_rw_i,
  input  logic              drq_i,
  input  logic              fdc_irq_i,
  input  logic [DATA_W-1:0] fdc_data_i,
  output logic              dma_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              host_rw_o,
  output logic              host_rw_oe_o,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  output logic              irq_pull_o,
  output logic              dack_o,
  output logic              fdc_dir_o,
  output logic [DATA_W-1:0] fdc_data_o
);
  logic fall, hold, step, clr, reg_we, dir;

  dma_phi2_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .phi2_i(phi2_i),
    .fall_o(fall)
  );

  dma_grab_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .drq_i    (drq_i),
    .fdc_irq_i(fdc_irq_i),
    .hold_o   (hold),
    .step_o   (step),
    .clr_o    (clr)
  );

  assign reg_we = phi2_i & ~host_rw_i
                & in_window(16'(host_addr_i), WIN_BASE, WIN_MASK);

  dma_addr_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .clr_i   (clr),
    .hold_i  (hold),
    .reg_we_i(reg_we),
    .reg_d_i (host_data_i[REG_W-1:0]),
    .addr_o  (addr_o),
    .dir_o   (dir)
  );

  assign dma_no         = ~hold;
  assign dack_o         = hold;
  assign addr_oe_o      = hold;
  assign host_rw_oe_o   = hold;
  assign host_rw_o      = ~dir;
  assign host_data_oe_o = hold & dir;
  assign host_data_o    = fdc_data_i;
  assign fdc_dir_o      = dir;
  assign fdc_data_o     = host_data_i;
  assign irq_pull_o     = fdc_irq_i & ~drq_i;

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_i |-> !irq_pull_o);

  p_no_data_without_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_oe_o |-> !host_data_oe_o && !host_rw_oe_o);

  p_write_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_data_oe_o |-> !host_rw_o);
endmodule

// File: tb/tb_retro_dma_engine.sv
`timescale 1ns/1ps
module tb_retro_dma_engine;
  logic clk = 0, rst_n = 0;
  logic phi2 = 0, phi_run = 0;
  logic [15:0] h_addr = 16'h0000;
  logic [7:0]  h_data = 8'h00, f_data = 8'h00;
  logic h_rw = 1, drq = 0, irq = 0;
  logic dma_n, a_oe, rw_o, rw_oe, d_oe, irq_pull, dack, fdir;
  logic [15:0] addr;
  logic [7:0]  d_out, f_out;
  int checks = 0, errors = 0, cyc = 0, phc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  retro_dma_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .phi2_i(phi2), .host_addr_i(h_addr),
    .host_data_i(h_data), .host_rw_i(h_rw), .drq_i(drq), .fdc_irq_i(irq),
    .fdc_data_i(f_data), .dma_no(dma_n), .addr_o(addr), .addr_oe_o(a_oe),
    .host_rw_o(rw_o), .host_rw_oe_o(rw_oe), .host_data_o(d_out),
    .host_data_oe_o(d_oe), .irq_pull_o(irq_pull), .dack_o(dack),
    .fdc_dir_o(fdir), .fdc_data_o(f_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // phi2: 4 clocks high, 4 low
  always @(posedge clk) begin
    #1;
    if (phi_run) begin
      phc = (phc + 1) % 8;
      phi2 = (phc < 4);
    end
    f_data = f_data + 8'd7;
  end

  // behavioural reference
  bit m_s1, m_s2, m_hold, m_dir;
  int m_cnt, m_page;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_hold = 0; m_dir = 0; m_cnt = 0; m_page = 0;
    end else begin
      bit f, was;
      f = m_s2 && !m_s1;
      was = m_hold;
      if (!was && phi2 && !h_rw && h_addr >= 16'hDFE0 && h_addr <= 16'hDFEF) begin
        m_page = h_data[4:0];
        m_dir  = h_data[5];
      end
      if (irq) begin m_hold = 0; m_cnt = 0; end
      else if (f) begin
        if (was) m_cnt = (m_cnt + 1) % 2048;
        m_hold = drq;
      end
      m_s2 = m_s1; m_s1 = phi2;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 dma_no", dma_n, !m_hold);
      check("R10 dack", dack, m_hold);
      check("R3 addr_oe", a_oe, m_hold);
      if (m_hold) check("R3 addr", addr, (m_page << 11) | m_cnt);
      check("R6 rw_oe", rw_oe, m_hold);
      if (m_hold) check("R6 rw", rw_o, !m_dir);
      check("R6 data_oe", d_oe, m_hold && m_dir);
      if (d_oe) check("R6 data", d_out, f_data);
      check("R6 fdc_dir", fdir, m_dir);
      check("R6 fdc_data", f_out, h_data);
      check("R8 irq", irq_pull, irq && !drq);
    end
  end

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(logic [15:0] a, logic [7:0] d, logic rw);
    while (phc != 0) ticks(1);
    h_addr = a; h_data = d; h_rw = rw;
    ticks(2);
    h_rw = 1; h_addr = 16'h0000; h_data = 8'h55;
  endtask

  task automatic wait_falls(int n);
    repeat (n) @(negedge phi2);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    ticks(3);
    check("R1 dma_no", dma_n, 1); check("R1 dack", dack, 0);
    check("R1 oe", {a_oe, rw_oe, d_oe}, 0); check("R1 irq", irq_pull, 0);
    rst_n = 1;
    ticks(2);
    phi_run = 1;
    check("R1 dir", fdir, 0);
    // page 0x15, disk->host
    reg_write(16'hDFE3, 8'h35, 0);
    reg_write(16'hDFF0, 8'h0A, 0);  // outside window
    reg_write(16'hDFE0, 8'h0A, 1);  // read access
    check("R5 dir", fdir, 1);
    drq = 1;
    wait_falls(1);
    check("R2 grab", dma_n, 0);
    check("R5 addr", addr, 16'hA800);
    reg_write(16'hDFE0, 8'h01, 0);  // while held
    wait_falls(3);
    check("R4 count", addr, 16'hA803);
    check("R6 rw write", rw_o, 0);
    drq = 0;
    wait_falls(1);
    check("R9 release", dma_n, 1);
    check("R5 kept", fdir, 1);
    drq = 1;
    wait_falls(1);
    check("R4 resume", addr, 16'hA804);
    irq = 1;
    check("R8 masked", irq_pull, 0);
    ticks(1);
    @(negedge clk);
    check("R7 release", dma_n, 1);
    drq = 0;
    #1 check("R8 pass", irq_pull, 1);
    ticks(4);
    irq = 0;
    // host->disk, page 0x03, wrap
    reg_write(16'hDFEF, 8'h03, 0);
    drq = 1;
    wait_falls(1);
    check("R7 cleared", addr, 16'h1800);
    check("R6 rw read", rw_o, 1);
    check("R6 no data", d_oe, 0);
    wait_falls(2048);
    check("R4 wrap", addr, 16'h1800);
    drq = 0;
    wait_falls(2);
    check("R9 idle", dma_n, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule